// File: doc/BRIEF.md
# Discharge Path Guard for a Two-Cell Battery Protector

This block decides when the discharge switch of a two-cell lithium pack may conduct. External comparators supply already-synchronized flags. Two flags per cell report a voltage at or below the deep-discharge level and a voltage at or above the recovery level. One flag reports excess load current, another reports a short, one reports that a charger is attached, and one requests shortened test delays. The block qualifies each fault with its own delay counter and latches the fault once the counter expires. From the latched state it drives a single discharge-enable output.

There are three fault classes, and each has its own release path. A latched current fault (excess current or short) turns on the V-minus pull-down resistor and clears once both current flags have stayed low for the release delay. A latched deep-discharge fault puts the block into standby and stops its own time base. Only an attached charger with both cells recovered can clear it. All delays are counted in ticks of an internal prescaler. The prescaler divides the system clock by `TICK_DIV`, and one tick nominally represents 100 µs.

Top module: `dsg_guard`

## Requirements
- R1: After reset, `dsg_en_o` is 1, `rres_en_o` is 0 and `stby_o` is 0. The prescaler and all delay counters start at zero.
- R2: Deep discharge latches on the tick on which either bit of `cell_low_i` has been continuously 1 for `UVP_TICKS` (1280) ticks. A return of both bits to 0 before that tick restarts the count from zero.
- R3: While `fast_i` is 1, the deep-discharge detection limit is `UVP_FAST_TICKS` (22) ticks instead of `UVP_TICKS`.
- R4: A latched deep discharge is released only when `chg_i` is 1 and both bits of `cell_rel_i` are 1 for `REL_TICKS` (12) consecutive ticks. Without the charger, recovered cells have no effect.
- R5: Excess current latches when `ocur_i` is 1 and `short_i` is 0 for `OCD_TICKS` (120) consecutive ticks. An earlier drop restarts the count.
- R6: A short latches when `short_i` has been 1 for `SCD_TICKS` (3) consecutive ticks.
- R7: A latched excess-current or short fault releases after `ocur_i` and `short_i` have both been 0 for `REL_TICKS` consecutive ticks.
- R8: `rres_en_o` is 1 exactly while an excess-current or short fault is latched.
- R9: When several detections complete on the same tick, short wins over excess current, and excess current wins over deep discharge. If deep discharge and excess current start together, the block enters the excess-current state.
- R10: `stby_o` is 1 while deep discharge is latched and `chg_i` is 0. While `stby_o` is 1 no tick is produced, so release counting cannot advance.
- R11: `dsg_en_o` is 1 only in the normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cell_low_i | input | 2 | Per-cell flag: voltage at or below the deep-discharge level |
| cell_rel_i | input | 2 | Per-cell flag: voltage at or above the recovery level |
| ocur_i | input | 1 | Excess discharge current flag |
| short_i | input | 1 | Short-circuit flag |
| chg_i | input | 1 | Charger attached |
| fast_i | input | 1 | Shortened deep-discharge delay request |
| dsg_en_o | output | 1 | Discharge switch enable |
| rres_en_o | output | 1 | V-minus pull-down resistor enable |
| stby_o | output | 1 | Standby; internal time base halted |

## Verification
The assertions assume that every flag input is already synchronous to `clk`. They also assume that a cell never reports low and recovered at the same time. The stimulus drives all inputs on the falling edge and clears `cell_rel_i` whenever it sets the matching `cell_low_i` bit. It holds each fault pattern for whole multiples of the tick period: either clearly short of a detection limit or clearly beyond it. The per-cycle reference model is therefore compared in states where no decision is ambiguous.

// File: rtl/dsg_guard_pkg.sv
package dsg_guard_pkg;

    typedef enum logic [1:0] {
        ST_NORM = 2'd0,
        ST_OCD  = 2'd1,
        ST_SCD  = 2'd2,
        ST_UVP  = 2'd3
    } guard_state_e;

endpackage

// File: rtl/dsg_tick_gen.sv
module dsg_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick_o = run_i && (pre_q == LAST);
        if (!run_i)           pre_d = '0;
        else if (pre_q == LAST) pre_d = '0;
        else                  pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/dsg_dly_cnt.sv
module dsg_dly_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   nxt;

    always_comb begin
        nxt   = {1'b0, cnt_q} + 1'b1;
        hit_o = run_i && tick_i && (nxt >= {1'b0, limit_i});
        if (!run_i)      cnt_d = '0;
        else if (tick_i) cnt_d = nxt[W-1:0];
        else             cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> cnt_q == '0) else $error("idle counter not zero"); // R2
endmodule

// File: rtl/dsg_guard.sv
module dsg_guard
    import dsg_guard_pkg::*;
#(
    parameter int TICK_DIV       = 4,
    parameter int UVP_TICKS      = 1280,
    parameter int UVP_FAST_TICKS = 22,
    parameter int OCD_TICKS      = 120,
    parameter int SCD_TICKS      = 3,
    parameter int REL_TICKS      = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cell_low_i,
    input  logic [1:0] cell_rel_i,
    input  logic       ocur_i,
    input  logic       short_i,
    input  logic       chg_i,
    input  logic       fast_i,
    output logic       dsg_en_o,
    output logic       rres_en_o,
    output logic       stby_o
);
    localparam int CW = $clog2(UVP_TICKS + 1);

    typedef struct packed {
        guard_state_e st;
    } guard_regs_t;

    guard_regs_t r_d, r_q;

    logic tick_w, run_tick;
    logic run_uvp, run_ocd, run_scd, run_rel;
    logic hit_uvp, hit_ocd, hit_scd, hit_rel;
    logic [CW-1:0] lim_uvp;

    assign run_tick = !(r_q.st == ST_UVP && !chg_i);

    dsg_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(run_tick), .tick_o(tick_w)
    );

    always_comb begin
        lim_uvp = fast_i ? CW'(UVP_FAST_TICKS) : CW'(UVP_TICKS);
        run_uvp = (r_q.st == ST_NORM) && (|cell_low_i);
        run_ocd = (r_q.st == ST_NORM) && ocur_i && !short_i;
        run_scd = (r_q.st == ST_NORM) && short_i;
        unique case (r_q.st)
            ST_OCD, ST_SCD: run_rel = !ocur_i && !short_i;
            ST_UVP:         run_rel = chg_i && (&cell_rel_i);
            default:        run_rel = 1'b0;
        endcase
    end

    dsg_dly_cnt #(.W(CW)) u_uvp (
        .clk(clk), .rst_n(rst_n), .run_i(run_uvp), .tick_i(tick_w),
        .limit_i(lim_uvp), .hit_o(hit_uvp)
    );
    dsg_dly_cnt #(.W(CW)) u_ocd (
        .clk(clk), .rst_n(rst_n), .run_i(run_ocd), .tick_i(tick_w),
        .limit_i(CW'(OCD_TICKS)), .hit_o(hit_ocd)
    );
    dsg_dly_cnt #(.W(CW)) u_scd (
        .clk(clk), .rst_n(rst_n), .run_i(run_scd), .tick_i(tick_w),
        .limit_i(CW'(SCD_TICKS)), .hit_o(hit_scd)
    );
    dsg_dly_cnt #(.W(CW)) u_rel (
        .clk(clk), .rst_n(rst_n), .run_i(run_rel), .tick_i(tick_w),
        .limit_i(CW'(REL_TICKS)), .hit_o(hit_rel)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_NORM: begin
                if (hit_scd)      r_d.st = ST_SCD;
                else if (hit_ocd) r_d.st = ST_OCD;
                else if (hit_uvp) r_d.st = ST_UVP;
            end
            default: begin
                if (hit_rel) r_d.st = ST_NORM;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_NORM};
        else        r_q <= r_d;
    end

    assign dsg_en_o  = (r_q.st == ST_NORM);
    assign rres_en_o = (r_q.st == ST_OCD) || (r_q.st == ST_SCD);
    assign stby_o    = (r_q.st == ST_UVP) && !chg_i;

    AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dsg_en_o |-> !rres_en_o && !stby_o) else $error("enable with fault"); // R11
    AST_STBY_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        stby_o |-> !tick_w) else $error("tick in standby"); // R10
    AST_UVP_NEEDS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dsg_en_o) && $past(r_q.st == ST_UVP)) |-> $past(chg_i))
        else $error("deep discharge left without charger"); // R4
    AST_RES_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rres_en_o) |-> $past(ocur_i || short_i))
        else $error("resistor on without current fault"); // R8
    AST_FAULT_FROM_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsg_en_o) |-> $past(tick_w)) else $error("fault off tick"); // R9
endmodule

// File: tb/sim_dsg_guard.sv
`timescale 1ns/1ps
module sim_dsg_guard;
    localparam int DIV = 4;
    localparam int N_UVP = 1280, N_FAST = 22, N_OCD = 120, N_SCD = 3, N_REL = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cell_low = 2'b00, cell_rel = 2'b11;
    logic ocur = 1'b0, shrt = 1'b0, chg = 1'b0, fast = 1'b0;
    logic dsg_en, rres_en, stby;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state: 0 normal, 1 excess current, 2 short, 3 deep discharge
    int m_st = 0, m_pre = 0, m_cu = 0, m_co = 0, m_cs = 0, m_cr = 0;

    always #4 clk = ~clk;

    dsg_guard #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cell_low_i(cell_low), .cell_rel_i(cell_rel),
        .ocur_i(ocur), .short_i(shrt), .chg_i(chg), .fast_i(fast),
        .dsg_en_o(dsg_en), .rres_en_o(rres_en), .stby_o(stby)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            bit halted, tk, ru, ro, rs, rr, hu, ho, hs, hr;
            int lim, nst;
            halted = (m_st == 3) && !chg;
            tk = !halted && (m_pre == DIV - 1);
            m_pre = (halted || m_pre == DIV - 1) ? 0 : m_pre + 1;
            ru = (m_st == 0) && (cell_low != 2'b00);
            ro = (m_st == 0) && ocur && !shrt;
            rs = (m_st == 0) && shrt;
            rr = (m_st == 1 || m_st == 2) ? (!ocur && !shrt)
               : (m_st == 3) ? (chg && cell_rel == 2'b11) : 1'b0;
            lim = fast ? N_FAST : N_UVP;
            hu = ru && tk && (m_cu + 1 >= lim);
            ho = ro && tk && (m_co + 1 >= N_OCD);
            hs = rs && tk && (m_cs + 1 >= N_SCD);
            hr = rr && tk && (m_cr + 1 >= N_REL);
            m_cu = !ru ? 0 : (tk ? m_cu + 1 : m_cu);
            m_co = !ro ? 0 : (tk ? m_co + 1 : m_co);
            m_cs = !rs ? 0 : (tk ? m_cs + 1 : m_cs);
            m_cr = !rr ? 0 : (tk ? m_cr + 1 : m_cr);
            nst = m_st;
            if (m_st == 0) begin
                if (hs) nst = 2; else if (ho) nst = 1; else if (hu) nst = 3;
            end else if (hr) nst = 0;
            m_st = nst;
        end
    end

    // per-cycle comparison against the model (R8, R10, R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dsg_en !== (m_st == 0)) begin
                fails++; $display("FAIL R11 dsg_en=%0b exp=%0b t=%0t", dsg_en, m_st == 0, $time);
            end
            checks++;
            if (rres_en !== (m_st == 1 || m_st == 2)) begin
                fails++; $display("FAIL R8 rres_en=%0b exp=%0b t=%0t", rres_en, (m_st == 1 || m_st == 2), $time);
            end
            checks++;
            if (stby !== (m_st == 3 && !chg)) begin
                fails++; $display("FAIL R10 stby=%0b exp=%0b t=%0t", stby, (m_st == 3 && !chg), $time);
            end
        end
    end

    task automatic ticks(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic expect3(input string req, input bit e_en, input bit e_res, input bit e_sb);
        checks++;
        if ({dsg_en, rres_en, stby} !== {e_en, e_res, e_sb}) begin
            fails++;
            $display("FAIL %s outputs=%b%b%b exp=%b%b%b", req, dsg_en, rres_en, stby, e_en, e_res, e_sb);
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect3("R1 in reset", 1, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect3("R1 after reset", 1, 0, 0);

        // R5: short burst cancelled, long burst latches
        ocur = 1; ticks(100); ocur = 0; ticks(2);
        expect3("R5 cancel", 1, 0, 0);
        ocur = 1; ticks(N_OCD + 5);
        expect3("R5 latch", 0, 1, 0);
        // R7: release after clear window
        ocur = 0; ticks(5);
        expect3("R7 still held", 0, 1, 0);
        ticks(10);
        expect3("R7 released", 1, 0, 0);

        // R6: short
        shrt = 1; ocur = 1; ticks(N_SCD + 2);
        expect3("R6 latch", 0, 1, 0);
        shrt = 0; ticks(5);
        expect3("R7 current still on", 0, 1, 0);
        ocur = 0; ticks(N_REL + 3);
        expect3("R7 short released", 1, 0, 0);

        // R2: deep discharge cancel then latch
        cell_low = 2'b01; cell_rel = 2'b10; ticks(1000);
        cell_low = 2'b00; cell_rel = 2'b11; ticks(2);
        expect3("R2 cancel", 1, 0, 0);
        cell_low = 2'b10; cell_rel = 2'b01; ticks(N_UVP + 10);
        expect3("R2 latch", 0, 0, 1);
        // R4: recovered cells without charger do nothing
        cell_low = 2'b00; cell_rel = 2'b11; ticks(30);
        expect3("R4 no charger", 0, 0, 1);
        chg = 1; ticks(5);
        expect3("R4 counting", 0, 0, 0);
        chg = 0; @(negedge clk);
        expect3("R10 standby again", 0, 0, 1);
        chg = 1; ticks(N_REL + 3);
        expect3("R4 released", 1, 0, 0);
        chg = 0;

        // R3: shortened delay
        fast = 1; cell_low = 2'b01; cell_rel = 2'b10; ticks(N_FAST + 3);
        expect3("R3 fast latch", 0, 0, 1);
        fast = 0; cell_low = 2'b00; cell_rel = 2'b11; chg = 1; ticks(N_REL + 3);
        expect3("R3 recovered", 1, 0, 0);
        chg = 0;

        // R9: deep discharge and excess current start together
        cell_low = 2'b11; cell_rel = 2'b00; ocur = 1; ticks(N_OCD + 5);
        expect3("R9 current wins", 0, 1, 0);
        ticks(N_UVP);
        expect3("R9 held in current state", 0, 1, 0);
        ocur = 0; cell_low = 2'b00; cell_rel = 2'b11; ticks(N_REL + 3);
        expect3("R9 released", 1, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule